// File: doc/BRIEF.md
# Horizontal Blanking Sequence Generator

This block produces the horizontal blanking pulse and the gated H1 drive for an image-sensor timing generator. A pixel counter is realigned to the horizontal sync input, and a line counter is realigned to the vertical sync input. The line number picks one of four vertical bands of lines. Each band names one of four stored blanking patterns. A pattern is a list of six pixel positions at which the blanking level flips, plus the H1 level to hold while blanking is asserted.

A configuration bit can bypass the internal pattern. The blanking then comes from an external pin, which is resynchronized and given a programmable active level. A separate H1 hold level applies in that mode. All settings are loaded through a single-cycle parallel write port. The selected pattern and its hold level are captured once per line, when the pixel counter restarts.

Top module: `hblk_seq_gen`

## Requirements
- R1: Address map for a write with `cfg_we` high. Flip position t (0..5) of pattern s (0..3) is at address 6*s+t and takes data bits [11:0]. Band k (0..3) start line is at 24+k and takes data bits [11:0]. Band k pattern selector is at 28+k and takes data bits [1:0]. The H1 hold level of pattern s is at 32+s and takes data bit 0. Address 36 holds three fields: bit 0 = source (1 = external), bit 1 = external active-high, bit 2 = external H1 hold level.
- R2: The pixel counter reads 0 in the cycle after the seventh rising clock edge that follows the first edge at which `hsync_n` is sampled low after being high. Otherwise it increments by one per clock and saturates at 4095.
- R3: The line counter clears to 0 on a falling edge of `vsync_n` and otherwise increments on each falling edge of `hsync_n`. When both sync inputs fall at the same edge, the clear wins.
- R4: The active band is the highest k (1..3) whose start line is less than or equal to the line counter, and band 0 otherwise. The band's selector picks the pattern.
- R5: In internal mode, the blanking level at pixel p is the parity of the number of the pattern's flip positions that are less than or equal to p. It therefore starts low at pixel 0 unless a flip sits at 0. Two equal positions cancel, and positions that are never reached have no effect.
- R6: While blanking is low, `h1_out` follows `h1_clk_in`. While blanking is high, `h1_out` is held at the selected hold level.
- R7: The pattern selection, flip positions and hold level are captured when the pixel counter restarts. A write during a line changes nothing until the next line.
- R8: In external mode, `blank_out` equals the external input as seen through a two-flop synchronizer, which adds two clock cycles of latency. It is inverted when the active-high bit is 0. The external hold level applies to H1.
- R9: After reset the outputs are as follows: blanking is low, the line counter is 0, and the pixel counter counts from 0. All flip positions reset to 4095 and all other settings reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, falling edge starts a line |
| vsync_n | input | 1 | Vertical sync, falling edge starts a frame |
| ext_blank_in | input | 1 | External blanking input, asynchronous |
| h1_clk_in | input | 1 | Free-running H1 clock to be gated |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration write address |
| cfg_wdata | input | 12 | Configuration write data |
| blank_out | output | 1 | Horizontal blanking level |
| h1_out | output | 1 | H1 after blanking hold |
| pix_cnt | output | 12 | Current pixel position in the line |
| line_cnt | output | 12 | Current line number in the frame |

## Verification
The bench first targets the restart delay. A counter that restarts one cycle early or late shifts every pixel comparison, so every pixel check fails. Patterns with a flip at pixel 0, with duplicated positions, and with positions past the line end catch designs that start the line high, toggle twice without cancelling, or react to unreached values. Writes to the live pattern mid-line catch designs that read configuration directly instead of latching it. A coincident vertical and horizontal sync catches a line counter that increments after clearing. The external path is driven with random data under both polarities, which exposes a wrong synchronizer depth or an inverted polarity.

// File: rtl/hblk_pkg.sv
package hblk_pkg;
    parameter int CW       = 12;
    parameter int NSEQ     = 4;
    parameter int NTOG     = 6;
    parameter int NREG     = 4;
    parameter int AW       = 6;
    parameter int LOCK_DLY = 7;

    localparam int SEQ_W     = $clog2(NSEQ);
    localparam int REG_W     = $clog2(NREG);
    localparam int DLY_W     = $clog2(LOCK_DLY + 1);
    localparam int ADDR_SCP  = NSEQ * NTOG;
    localparam int ADDR_PTR  = ADDR_SCP + NREG;
    localparam int ADDR_MASK = ADDR_PTR + NREG;
    localparam int ADDR_EXT  = ADDR_MASK + NSEQ;

    typedef logic [CW-1:0]    pos_t;
    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic [NSEQ*NTOG-1:0][CW-1:0] tog;
        logic [NREG-1:0][CW-1:0]      scp;
        logic [NREG-1:0][SEQ_W-1:0]   ptr;
        logic [NSEQ-1:0]              mask;
        logic                         dir;
        logic                         pol;
        logic                         xmask;
    } cfg_t;
endpackage

// File: rtl/hblk_cfg_regs.sv
module hblk_cfg_regs
    import hblk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output cfg_t          cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int i = 0; i < NSEQ*NTOG; i++)
                if (int'(addr) == i) cfg_d.tog[i] = wdata;
            for (int k = 0; k < NREG; k++) begin
                if (int'(addr) == ADDR_SCP + k) cfg_d.scp[k] = wdata;
                if (int'(addr) == ADDR_PTR + k) cfg_d.ptr[k] = wdata[SEQ_W-1:0];
            end
            for (int s = 0; s < NSEQ; s++)
                if (int'(addr) == ADDR_MASK + s) cfg_d.mask[s] = wdata[0];
            if (int'(addr) == ADDR_EXT) begin
                cfg_d.dir   = wdata[0];
                cfg_d.pol   = wdata[1];
                cfg_d.xmask = wdata[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.tog <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/hblk_timebase.sv
module hblk_timebase
    import hblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n,
    input  logic vsync_n,
    output pos_t pix,
    output pos_t pix_next,
    output pos_t line,
    output logic line_start
);
    typedef struct packed {
        logic             hs;
        logic             vs;
        logic             armed;
        logic [DLY_W-1:0] dly;
        pos_t             pix;
        pos_t             line;
    } tb_t;

    tb_t  tb_d, tb_q;
    logic hs_fall, vs_fall, restart;

    always_comb begin
        tb_d    = tb_q;
        hs_fall = tb_q.hs & ~hsync_n;
        vs_fall = tb_q.vs & ~vsync_n;
        restart = tb_q.armed && (tb_q.dly == DLY_W'(LOCK_DLY));
        tb_d.hs = hsync_n;
        tb_d.vs = vsync_n;
        if (restart) begin
            tb_d.pix   = '0;
            tb_d.armed = 1'b0;
        end else begin
            if (tb_q.pix != '1) tb_d.pix = tb_q.pix + 1'b1;
            if (tb_q.armed)     tb_d.dly = tb_q.dly + 1'b1;
        end
        if (hs_fall) begin
            tb_d.armed = 1'b1;
            tb_d.dly   = DLY_W'(1);
        end
        if (vs_fall)      tb_d.line = '0;
        else if (hs_fall) tb_d.line = tb_q.line + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q    <= '0;
            tb_q.hs <= 1'b1;
            tb_q.vs <= 1'b1;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign pix        = tb_q.pix;
    assign pix_next   = tb_d.pix;
    assign line       = tb_q.line;
    assign line_start = restart;
endmodule

// File: rtl/hblk_region.sv
module hblk_region
    import hblk_pkg::*;
(
    input  pos_t                    line,
    input  logic [NREG-1:0][CW-1:0] scp,
    output reg_t                    region
);
    always_comb begin
        region = '0;
        for (int k = 1; k < NREG; k++)
            if (line >= scp[k]) region = REG_W'(k);
    end
endmodule

// File: rtl/hblk_seq_gen.sv
module hblk_seq_gen
    import hblk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_n,
    input  logic          vsync_n,
    input  logic          ext_blank_in,
    input  logic          h1_clk_in,
    input  logic          cfg_we,
    input  logic [5:0]    cfg_addr,
    input  logic [11:0]   cfg_wdata,
    output logic          blank_out,
    output logic          h1_out,
    output logic [11:0]   pix_cnt,
    output logic [11:0]   line_cnt
);
    typedef struct packed {
        logic [NTOG-1:0][CW-1:0] tog;
        logic                    mask;
        logic                    blank;
        logic [1:0]              ext_sync;
    } act_t;

    cfg_t  cfg;
    pos_t  pix, pix_next, line;
    logic  line_start;
    reg_t  region;
    seq_t  sel_seq;
    act_t  act_d, act_q;
    logic [NTOG-1:0] hit;
    logic  ext_level, mask_lvl;
    logic  ext_dir_w, ext_pol_w;

    hblk_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
    );

    hblk_timebase u_time (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .pix(pix), .pix_next(pix_next), .line(line), .line_start(line_start)
    );

    hblk_region u_region (
        .line(line), .scp(cfg.scp), .region(region)
    );

    assign sel_seq = cfg.ptr[region];

    always_comb begin
        act_d          = act_q;
        act_d.ext_sync = {act_q.ext_sync[0], ext_blank_in};
        if (line_start) begin
            for (int t = 0; t < NTOG; t++)
                act_d.tog[t] = cfg.tog[int'(sel_seq)*NTOG + t];
            act_d.mask = cfg.mask[sel_seq];
        end
        for (int t = 0; t < NTOG; t++)
            hit[t] = (act_d.tog[t] == pix_next);
        if (line_start)          act_d.blank = ^hit;
        else if (pix != '1)      act_d.blank = act_q.blank ^ (^hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q     <= '0;
            act_q.tog <= '1;
        end else begin
            act_q <= act_d;
        end
    end

    assign ext_dir_w = cfg.dir;
    assign ext_pol_w = cfg.pol;
    assign ext_level = cfg.pol ? act_q.ext_sync[1] : ~act_q.ext_sync[1];
    assign blank_out = cfg.dir ? ext_level : act_q.blank;
    assign mask_lvl  = cfg.dir ? cfg.xmask : act_q.mask;
    assign h1_out    = blank_out ? mask_lvl : h1_clk_in;
    assign pix_cnt   = pix;
    assign line_cnt  = line;
endmodule

// File: rtl/hblk_seq_chk.sv
module hblk_seq_chk
    import hblk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        vsync_n,
    input logic        ext_blank_in,
    input logic        h1_clk_in,
    input logic        blank_out,
    input logic        h1_out,
    input logic [11:0] pix_cnt,
    input logic [11:0] line_cnt,
    input logic        ext_dir,
    input logic        ext_pol
);
    logic vs_prev, e1, e2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_prev <= 1'b1;
            e1      <= 1'b0;
            e2      <= 1'b0;
        end else begin
            vs_prev <= vsync_n;
            e1      <= ext_blank_in;
            e2      <= e1;
        end
    end

    p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt != '1) |=> (pix_cnt == CW'($past(pix_cnt) + 1'b1) || pix_cnt == '0));

    p_pix_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt == '1) |=> (pix_cnt == '1 || pix_cnt == '0));

    p_line_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_prev && !vsync_n) |=> (line_cnt == '0));

    p_ext_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dir |-> (blank_out == (ext_pol ? e2 : !e2)));

    p_h1_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_out |-> (h1_out == h1_clk_in));
endmodule

bind hblk_seq_gen hblk_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .ext_blank_in(ext_blank_in),
    .h1_clk_in(h1_clk_in), .blank_out(blank_out), .h1_out(h1_out),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .ext_dir(ext_dir_w), .ext_pol(ext_pol_w)
);

// File: tb/sim_hblk_seq_gen.sv
`timescale 1ns/1ps
module sim_hblk_seq_gen;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        hsync_n = 1'b1, vsync_n = 1'b1;
    logic        ext_blank_in = 1'b0, h1_clk_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        blank_out, h1_out;
    logic [11:0] pix_cnt, line_cnt;

    hblk_seq_gen u0 (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .ext_blank_in(ext_blank_in), .h1_clk_in(h1_clk_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .blank_out(blank_out), .h1_out(h1_out),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    int sh_tog [24];
    int sh_scp [4];
    int sh_ptr [4];
    int sh_mask[4];
    int lt[6];
    int lm;
    int line_m = 0;
    bit done = 0;
    int hist[100];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 12'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 24)      sh_tog[a]       = d;
        else if (a < 28) sh_scp[a-24]    = d;
        else if (a < 32) sh_ptr[a-28]    = d & 3;
        else if (a < 36) sh_mask[a-32]   = d & 1;
    endtask

    function automatic int region_of(int ln);
        int r = 0;
        for (int k = 1; k < 4; k++) if (ln >= sh_scp[k]) r = k;
        return r;
    endfunction

    function automatic int blank_at(int p);
        int c = 0;
        for (int t = 0; t < 6; t++) if (lt[t] <= p) c++;
        return c & 1;
    endfunction

    // one line: sync edge, 7-cycle restart, n checked pixels, optional mid-line write
    task automatic run_line(int n, bit with_vd, int mid);
        int s, eb, wa;
        @(negedge clk);
        hsync_n = 1'b0;
        if (with_vd) vsync_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hsync_n = 1'b1; vsync_n = 1'b1;
        repeat (7) @(posedge clk);
        line_m = with_vd ? 0 : (line_m + 1) % 4096;
        s  = sh_ptr[region_of(line_m)];       // R4 band lookup
        for (int t = 0; t < 6; t++) lt[t] = sh_tog[s*6 + t];
        lm = sh_mask[s];
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            h1_clk_in = 1'($urandom % 2);
            if (p == mid) begin
                wa = s*6 + (p % 6);
                cfg_we = 1'b1; cfg_addr = 6'(wa); cfg_wdata = 12'(p + 1);
                sh_tog[wa] = p + 1;
            end else begin
                cfg_we = 1'b0;
            end
            #1;
            if (p == 0) chk(with_vd ? "R3 line clear" : "R3 line step", int'(line_cnt), line_m);
            chk("R2 pixel", int'(pix_cnt), p);
            eb = blank_at(p);
            chk((mid >= 0 && p > mid) ? "R7 blank" : "R5 R4 blank", int'(blank_out), eb);
            chk("R6 R1 h1", int'(h1_out), eb ? lm : int'(h1_clk_in));
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 24; i++) sh_tog[i] = 4095;
        for (int k = 0; k < 4; k++) begin sh_scp[k] = 0; sh_ptr[k] = 0; sh_mask[k] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 blank", int'(blank_out), 0);
        chk("R9 line", int'(line_cnt), 0);
        chk("R9 pixel", int'(pix_cnt), 1);
        chk("R9 h1", int'(h1_out), int'(h1_clk_in));

        // directed pattern 0: flip at 0, duplicated 5s, unreached 4000
        wr(0, 0); wr(1, 5); wr(2, 5); wr(3, 20); wr(4, 4000); wr(5, 30);
        wr(32, 1);
        wr(24, 0); wr(25, 2); wr(26, 4); wr(27, 6);
        wr(28, 0);
        for (int k = 1; k < 4; k++) wr(28 + k, k);

        for (int f = 0; f < 3; f++) begin
            for (int s = 1; s < 4; s++) begin
                for (int t = 0; t < 6; t++) wr(s*6 + t, int'($urandom % 100));
                wr(32 + s, int'($urandom % 2));
            end
            if (f > 0) for (int k = 0; k < 4; k++) wr(28 + k, int'($urandom % 4));
            run_line(70, 1'b1, -1);
            for (int l = 1; l < 8; l++)
                run_line(70, 1'b0, (f == 1 || l == 3) ? 30 : -1);
        end

        // vertical sync alone clears the line counter
        @(negedge clk); vsync_n = 1'b0;
        @(posedge clk);
        @(negedge clk); vsync_n = 1'b1; #1;
        chk("R3 vsync clear", int'(line_cnt), 0);
        line_m = 0;
        run_line(40, 1'b0, -1);

        // saturation of the pixel counter
        repeat (4200) @(posedge clk);
        @(negedge clk); #1;
        chk("R2 saturate", int'(pix_cnt), 4095);

        // external source, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            int xm;
            int ee;
            xm = int'($urandom % 2);
            wr(36, 1 | (pol << 1) | (xm << 2));
            for (int n = 0; n < 100; n++) begin
                @(negedge clk);
                ext_blank_in = 1'($urandom % 2);
                h1_clk_in    = 1'($urandom % 2);
                hist[n] = int'(ext_blank_in);
                #1;
                if (n >= 2) begin
                    ee = pol ? hist[n-2] : 1 - hist[n-2];
                    chk("R8 ext blank", int'(blank_out), ee);
                    chk("R8 ext h1", int'(h1_out), ee ? xm : int'(h1_clk_in));
                end
            end
        end
        wr(36, 0);
        run_line(50, 1'b0, -1);

        done = 1;
        report();
    end
endmodule